// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block drives the two-wire PHY management bus of an Ethernet port. The host launches a transaction with a single 32-bit write to a command/data register. The engine then divides the system clock to make the management clock (MDC), sends a run of ones as preamble, and shifts the command word out on the data line, MSB first. For a read, it lets go of the data line from the turnaround bits onward, samples sixteen bits from the PHY on the rising MDC edges, and places them in the low half of the same register.

When the frame ends, a sticky completion flag is raised. The host clears it by writing a word with bit 23 set to the event port. The host also programs a speed value. MDC then runs with a period of twice that value in system clocks, and a speed of zero blocks every transaction. Only one transaction can be in flight at a time: a `busy` flag is high while a frame is being sent, and command writes made during that time are dropped.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy` and `done_evt` are low, `data_reg` is zero, and `mdc` and `mdio_oe` stay low whenever `busy` is low.
- R2: A command sends PRE_LEN (32) ones followed by the 32 command bits, MSB first: ST[31:30], OP[29:28], PHY[27:23], REG[22:18], TA[17:16], DATA[15:0]. Each bit is valid at the rising edge of `mdc`. For a non-read opcode, `mdio_oe` is high for the whole frame.
- R3: While `busy`, `mdc` is high for `spd` system clocks and then low for `spd` clocks, so its period is 2·`spd`. Here `spd` is the speed value in effect when the command was accepted.
- R4: OP = 2'b10 marks a read. From the first TA bit (command bit 17) to the end of the frame, `mdio_oe` is low. The 16 bits on `mdio_i` at the last 16 rising `mdc` edges are stored MSB first in `data_reg[15:0]`, and `data_reg[31:16]` keeps the command's upper half.
- R5: In the cycle where `busy` falls at the end of a frame, `done_evt` (event bit 23) becomes 1 and stays set.
- R6: An event write with bit 23 set clears `done_evt`. An event write with bit 23 clear leaves it unchanged.
- R7: A command write while `busy` is ignored: the current frame runs on unchanged, no extra bits follow it, and `data_reg` does not take the new word.
- R8: While the speed value is zero, a command write is ignored: `busy` stays low, `mdc` stays low, and `data_reg` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command/data register |
| cmd_word | input | 32 | Packed command word |
| spd_wr | input | 1 | Write strobe for the speed value |
| spd_val | input | DIV_W | MDC half period in system clocks; 0 disables transfers |
| evt_wr | input | 1 | Write strobe for the event register |
| evt_word | input | 32 | Event write data; a one in bit 23 clears completion |
| data_reg | output | 32 | Command/data register; read result in bits 15:0 |
| done_evt | output | 1 | Sticky completion flag (event bit 23) |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the engine |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data from the bus |

## Verification
The assertions take for granted that `mdio_i` is already synchronous to `clk`. They also take for granted that the speed value latched when a command is accepted is nonzero. The engine itself guarantees this second point, because it refuses commands while the speed is zero. The stimulus changes every input only on falling clock edges. It drives `mdio_i` from a PHY model that is indexed by the count of observed MDC rising edges, so read data is stable well before the edge that samples it. Commands made while the engine is busy or while the speed is zero are injected on purpose, to show that they are dropped without touching the bus.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W     = 32;
  localparam int RDATA_W   = 16;
  localparam int TA_BIT    = 17;
  localparam int DONE_BIT  = 23;
  localparam logic [1:0] OP_READ = 2'b10;

  function automatic logic word_is_read(input logic [CMD_W-1:0] w);
    return w[29:28] == OP_READ;
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + DIV_W'(1);
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < half));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CMD_W-1:0]   cmd,
  input  logic               tick,
  input  logic               mdio_i,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               active,
  output logic               finish,
  output logic [RDATA_W-1:0] rd_bits
);
  localparam int FRAME = PRE_LEN + CMD_W;
  localparam int IDX_W = $clog2(FRAME + 1);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(FRAME - 1);
  localparam logic [IDX_W-1:0] REL_IDX = IDX_W'(PRE_LEN + CMD_W - 1 - TA_BIT);
  localparam logic [IDX_W-1:0] SMP_IDX = IDX_W'(FRAME - RDATA_W);

  logic [IDX_W-1:0]   idx_q;
  logic [CMD_W-1:0]   cmd_q;
  logic               rd_q;
  logic               mdc_q, o_q, oe_q, act_q;
  logic [RDATA_W-1:0] sh_q;

  function automatic logic bit_val(input logic [CMD_W-1:0] w, input logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] off;
    off = LAST - i;
    if (i < IDX_W'(PRE_LEN)) return 1'b1;
    return w[off[$clog2(CMD_W)-1:0]];
  endfunction

  assign finish = act_q && tick && mdc_q && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0; cmd_q <= '0; rd_q <= 1'b0; sh_q <= '0;
      mdc_q <= 1'b0; o_q <= 1'b0; oe_q <= 1'b0; act_q <= 1'b0;
    end else if (start && !act_q) begin
      act_q <= 1'b1;
      idx_q <= '0;
      cmd_q <= cmd;
      rd_q  <= word_is_read(cmd);
      mdc_q <= 1'b0;
      o_q   <= bit_val(cmd, '0);
      oe_q  <= 1'b1;
      sh_q  <= '0;
    end else if (act_q && tick) begin
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (rd_q && idx_q >= SMP_IDX)
          sh_q <= {sh_q[RDATA_W-2:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        if (idx_q == LAST) begin
          act_q <= 1'b0;
          idx_q <= '0;
          o_q   <= 1'b0;
          oe_q  <= 1'b0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          o_q   <= bit_val(cmd_q, idx_q + IDX_W'(1));
          oe_q  <= !(rd_q && (idx_q + IDX_W'(1)) >= REL_IDX);
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign active  = act_q;
  assign rd_bits = sh_q;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> (!mdc_q && !oe_q));
  a_r3_mdc_on_tick_only: assert property (@(posedge clk) disable iff (rst)
    (act_q && !tick) |=> $stable(mdc_q));
  a_r4_released_in_data: assert property (@(posedge clk) disable iff (rst)
    (act_q && rd_q && idx_q >= SMP_IDX) |-> !oe_q);
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_word,
  input  logic             spd_wr,
  input  logic [DIV_W-1:0] spd_val,
  input  logic             evt_wr,
  input  logic [31:0]      evt_word,
  output logic [31:0]      data_reg,
  output logic             done_evt,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam logic [31:0] DONE_MASK = 32'd1 << DONE_BIT;

  logic [DIV_W-1:0]   spd_q, half_q;
  logic [CMD_W-1:0]   data_q;
  logic               evt_q;
  logic               active, finish, tick, accept, clr_hit;
  logic [RDATA_W-1:0] rd_bits;

  assign accept  = cmd_wr && !active && (spd_q != '0);
  assign clr_hit = evt_wr && ((evt_word & DONE_MASK) != '0);

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(active), .half(half_q), .tick(tick)
  );

  mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .cmd(cmd_word), .tick(tick),
    .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .active(active), .finish(finish), .rd_bits(rd_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spd_q  <= '0;
      half_q <= '0;
      data_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (spd_wr) spd_q <= spd_val;
      if (accept) begin
        data_q <= cmd_word;
        half_q <= spd_q;
      end else if (finish && word_is_read(data_q)) begin
        data_q[RDATA_W-1:0] <= rd_bits;
      end
      if (finish)       evt_q <= 1'b1;
      else if (clr_hit) evt_q <= 1'b0;
    end
  end

  assign data_reg = data_q;
  assign done_evt = evt_q;
  assign busy     = active;

  a_r5_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> evt_q);
  a_r8_zero_speed_blocks: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !active && spd_q == '0) |=> !active);
  a_r7_upper_held: assert property (@(posedge clk) disable iff (rst)
    active |=> $stable(data_q[31:16]));
endmodule

// File: tb/sim_mdio_frame_ctrl.sv
module sim_mdio_frame_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0, spd_wr = 1'b0, evt_wr = 1'b0;
  logic [31:0] cmd_word = '0, evt_word = '0;
  logic [7:0]  spd_val = '0;
  logic [31:0] data_reg;
  logic        done_evt, busy, mdc, mdio_o, mdio_oe, mdio_i;

  int nchk = 0, nfail = 0, wd = 0;
  int bcnt = 0, cyc = 0, exp_half = 1;
  logic mdc_prev = 1'b0;
  logic [15:0] phy_val = '0;
  logic [1:0]  exp_q[$];

  always #10 clk = ~clk;

  mdio_frame_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .spd_wr(spd_wr), .spd_val(spd_val), .evt_wr(evt_wr), .evt_word(evt_word),
    .data_reg(data_reg), .done_evt(done_evt), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic phy_bit(input int n, input logic [15:0] v);
    if (n >= 48 && n <= 63) return v[63 - n];
    return 1'b1;
  endfunction
  assign mdio_i = phy_bit(bcnt, phy_val);

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  // monitor: pops one expected bit per rising mdc
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (mdc && !mdc_prev) begin
        if (bcnt > 0) check(cyc == 2*exp_half, "R3 mdc period", cyc, 2*exp_half);
        cyc = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected bit on bus", bcnt, 0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          if (e[1]) check(mdio_oe && mdio_o == e[0], "R2 frame bit", {mdio_oe, mdio_o}, e);
          else      check(!mdio_oe, "R4 released bit", mdio_oe, 0);
        end
        bcnt++;
      end
      if (!busy) bcnt = 0;
    end
    mdc_prev = mdc;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      summary();
      $finish;
    end
  end

  task automatic push_frame(input logic [31:0] w);
    logic rd;
    rd = (w[29:28] == 2'b10);
    for (int i = 0; i < 32; i++) exp_q.push_back(2'b11);
    for (int i = 31; i >= 0; i--) exp_q.push_back({!(rd && i <= 17), w[i]});
  endtask

  task automatic set_speed(input logic [7:0] v);
    @(negedge clk); spd_wr = 1'b1; spd_val = v;
    @(negedge clk); spd_wr = 1'b0;
    exp_half = v;
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    check(!busy, "R5 busy dropped", busy, 0);
    check(done_evt, "R5 done set at end", done_evt, 1);
    check(exp_q.size() == 0, "R2 all bits sent", exp_q.size(), 0);
  endtask

  task automatic clear_evt(input logic [31:0] w);
    @(negedge clk); evt_wr = 1'b1; evt_word = w;
    @(negedge clk); evt_wr = 1'b0;
  endtask

  initial begin
    logic [31:0] w1, w2, w3, w4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!mdc && !mdio_oe && !busy && !done_evt, "R1 reset outputs",
          {mdc, mdio_oe, busy, done_evt}, 0);
    check(data_reg == 0, "R1 reset data", data_reg, 0);

    // write, half period 2
    set_speed(8'd2);
    w1 = {2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hA5C3};
    push_frame(w1); issue(w1);
    check(busy, "R2 busy after command", busy, 1);
    wait_end();
    check(data_reg == w1, "R2 data reg after write", data_reg, w1);

    // event clear
    clear_evt(32'hFF7F_FFFF);
    check(done_evt, "R6 clear without bit 23", done_evt, 1);
    clear_evt(32'h0080_0000);
    check(!done_evt, "R6 clear with bit 23", done_evt, 0);

    // read, half period 3
    set_speed(8'd3);
    phy_val = 16'h1234;
    w2 = {2'b01, 2'b10, 5'd1, 5'd2, 2'b00, 16'h0000};
    push_frame(w2); issue(w2);
    wait_end();
    check(data_reg == {w2[31:16], 16'h1234}, "R4 read result", data_reg, {w2[31:16], 16'h1234});
    clear_evt(32'h0080_0000);

    // command while busy
    set_speed(8'd2);
    phy_val = 16'hBEEF;
    w3 = {2'b01, 2'b10, 5'd7, 5'd31, 2'b00, 16'h0000};
    push_frame(w3); issue(w3);
    repeat (10) @(negedge clk);
    issue({2'b01, 2'b01, 5'd2, 5'd4, 2'b10, 16'h5555});
    wait_end();
    check(data_reg == {w3[31:16], 16'hBEEF}, "R7 busy write ignored", data_reg, {w3[31:16], 16'hBEEF});
    repeat (40) @(negedge clk);
    check(!busy && !mdc, "R7 no second frame", {busy, mdc}, 0);
    clear_evt(32'h0080_0000);

    // zero speed
    set_speed(8'd0);
    issue(32'h5000_1111);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 0 || k == 19) check(!busy && !mdc, "R8 zero speed idle", {busy, mdc}, 0);
    end
    check(data_reg == {w3[31:16], 16'hBEEF}, "R8 data unchanged", data_reg, {w3[31:16], 16'hBEEF});
    check(!done_evt, "R8 no completion", done_evt, 0);

    // minimum divide, write
    set_speed(8'd1);
    w4 = {2'b01, 2'b01, 5'd31, 5'd0, 2'b10, 16'h0001};
    push_frame(w4); issue(w4);
    wait_end();
    check(data_reg == w4, "R2 min speed write", data_reg, w4);

    summary();
    $finish;
  end
endmodule